// File: doc/BRIEF.md
# Sixteen-Bit Interval Timer with Dual Capture/Compare

The block is a 16-bit up-counter with two 16-bit registers that are matched against the count. The first register sets the period, or serves as a plain compare point. The second register can be switched between two uses. In compare use it raises its own match pulse. In capture use it takes a snapshot of the count when a selected edge arrives on the external timer pin. The counter has three modes. It can free-run and wrap. It can return to zero on the clock after it equals the first register. It can return to zero when a valid edge arrives on the pin.

Software writes the registers through a one-cycle write port. A small two-state machine (STOP, RUN) follows the run bit in the control register. The transition STOP to RUN is taken when run is 1, and RUN to STOP is taken when run is 0. Each state otherwise holds. In STOP the count is held at zero, so clearing the run bit and setting it again restarts the timer from zero. The timer pin is shared. When the control register makes the pin a driven output, the pin carries a level that toggles on every match with the first register, and edges on the pin are not observed.

Top module: `tmr16_dualcc`

## Requirements
- R1: After reset the count, both match registers and the control register are zero. `irq_a_o`, `irq_b_o`, `tmr_out_o` and `tmr_oe_o` are low.
- R2: A write takes place on a clock with `wr_en` high. `wr_addr` 0 selects the first register, 1 the second register and 2 the control register; address 3 is ignored. Control fields: [1:0] mode (00 free-run, 01 clear on first-register match, 10 clear on pin edge, 11 behaves as 00), [2] run, [3] second register as capture (1) or compare (0), [5:4] edge select (00 none, 01 rising, 10 falling, 11 both), [6] pin is an output. The second register is visible on `cmpb_o`.
- R3: The state register takes the value of the run bit one clock after the run bit is written. In STOP the count goes to zero. In RUN the count rises by one per clock unless a clear applies.
- R4: In free-run mode the count wraps from FFFFh to 0000h and keeps counting.
- R5: In clear-on-match mode with a nonzero first register, the count is 0 on the clock after the cycle in which it equals the first register.
- R6: In clear-on-edge mode the count is 0 on the clock after the cycle in which a valid pin edge is detected.
- R7: `irq_a_o` is high in every RUN cycle where the count equals the first register. When the second register is in compare use, `irq_b_o` is high in every RUN cycle where the count equals the second register. Both are subject to R8.
- R8: A match at count 0000h is reported only when the count was FFFFh in RUN on the previous cycle. A zero compare value therefore fires only after a roll-over, never at start.
- R9: If a compare register is written with a value below the current count, no match for it occurs until the count has wrapped.
- R10: In capture use, a valid edge loads the second register with the count present in the detection cycle. `irq_b_o` is then high for exactly the following cycle. Compare matches of the second register raise nothing in this use.
- R11: The pin passes through two synchronizing flops. A level change present before clock edge k is detected in the cycle between edges k+1 and k+2. It is counted as valid only for the polarity chosen by the edge select field.
- R12: With control bit 6 set, `tmr_oe_o` is high, pin edges neither capture nor clear, and `tmr_out_o` toggles on the clock after each `irq_a_o` cycle. With bit 6 clear, `tmr_out_o` holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 16 | Write data |
| tmr_pin_i | input | 1 | External timer pin, input side |
| cnt_o | output | 16 | Current count |
| cmpb_o | output | 16 | Second register contents (compare value or capture) |
| irq_a_o | output | 1 | First-register match pulse |
| irq_b_o | output | 1 | Second-register match or capture pulse |
| tmr_out_o | output | 1 | Timer output level for the pin |
| tmr_oe_o | output | 1 | Pin drive enable |

## Verification
The hardest case to reach from the ports is the full wrap, because it takes 65,536 running clocks. That wrap is where a zero compare value and a lowered compare value finally produce their pulses. The stimulus builds one long free-running pass for this. The second register holds zero. The first register is lowered below the live count after about 520 clocks. Across the roll-over, the bench counts exactly one pulse of each kind and none before the wrap. The capture path and the pin-direction interlock depend on the two-flop latency. These are reached with a pin that toggles at random under every edge select, alongside random register values and mode changes. Every cycle is compared with a bench model.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        MODE_FREE      = 2'b00,
        MODE_CLR_MATCH = 2'b01,
        MODE_CLR_EDGE  = 2'b10,
        MODE_ALT_FREE  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } tedge_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } tstate_e;

    typedef enum logic [1:0] {
        ADDR_CMPA = 2'b00,
        ADDR_CMPB = 2'b01,
        ADDR_CTRL = 2'b10,
        ADDR_NONE = 2'b11
    } taddr_e;

    // bit 6 pin output, [5:4] edge, 3 capture, 2 run, [1:0] mode
    typedef struct packed {
        logic   out_en;
        tedge_e edge_sel;
        logic   cap_sel;
        logic   run;
        tmode_e mode;
    } tctrl_t;

    localparam int unsigned CTRL_W = $bits(tctrl_t);

endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync
    import tmr16_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_i,
    input  tedge_e sel_i,
    input  logic   block_i,
    output logic   edge_o
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    logic [TOP:0] chain_q;
    logic         last_q;
    logic         settled;
    logic         rise;
    logic         fall;
    logic         picked;

    assign settled = chain_q[TOP];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[TOP-1:0], pin_i};
            last_q  <= settled;
        end
    end

    assign rise = settled & ~last_q;
    assign fall = ~settled & last_q;

    always_comb begin
        unique case (sel_i)
            EDGE_NONE: picked = 1'b0;
            EDGE_RISE: picked = rise;
            EDGE_FALL: picked = fall;
            EDGE_BOTH: picked = rise | fall;
        endcase
    end

    assign edge_o = picked & ~block_i;

endmodule

// File: rtl/tmr16_match.sv
module tmr16_match #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    input  logic         running_i,
    input  logic         wrapped_i,
    output logic         hit_o
);
    logic equal;
    logic nonzero;

    assign equal   = (cnt_i == cmp_i);
    assign nonzero = |cnt_i;
    assign hit_o   = running_i & equal & (nonzero | wrapped_i);

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
    import tmr16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_req_i,
    input  tmode_e       mode_i,
    input  logic         period_hit_i,
    input  logic         ext_edge_i,
    output logic [W-1:0] cnt_o,
    output logic         running_o,
    output logic         wrapped_o
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = W'(1);

    tstate_e      state_q;
    tstate_e      state_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         wrap_q;
    logic         wrap_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run_req_i)  state_d = ST_RUN;
            ST_RUN:  if (!run_req_i) state_d = ST_STOP;
        endcase
    end

    always_comb begin
        cnt_d  = cnt_q;
        wrap_d = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                cnt_d  = '0;
                wrap_d = 1'b0;
            end
            ST_RUN: begin
                wrap_d = (cnt_q == ALL_ONES);
                unique case (mode_i)
                    MODE_CLR_MATCH: cnt_d = period_hit_i ? '0 : cnt_q + ONE;
                    MODE_CLR_EDGE:  cnt_d = ext_edge_i   ? '0 : cnt_q + ONE;
                    default:        cnt_d = cnt_q + ONE;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wrap_q <= wrap_d;
        end
    end

    assign cnt_o     = cnt_q;
    assign running_o = (state_q == ST_RUN);
    assign wrapped_o = wrap_q;

endmodule

// File: rtl/tmr16_dualcc.sv
module tmr16_dualcc
    import tmr16_pkg::*;
#(
    parameter int unsigned W           = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         tmr_pin_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmpb_o,
    output logic         irq_a_o,
    output logic         irq_b_o,
    output logic         tmr_out_o,
    output logic         tmr_oe_o
);
    localparam int unsigned NCMP = 2;

    tctrl_t       ctrl_q;
    logic [W-1:0] cmpa_q;
    logic [W-1:0] cmpb_q;
    logic         cap_flag_q;
    logic         tout_q;
    logic [W-1:0] cnt;
    logic         running;
    logic         wrapped;
    logic         edge_ok;
    logic [NCMP-1:0] hit;
    taddr_e       wsel;

    assign wsel = taddr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmpa_q <= '0;
        end else if (wr_en) begin
            if (wsel == ADDR_CTRL) ctrl_q <= tctrl_t'(wr_data[CTRL_W-1:0]);
            if (wsel == ADDR_CMPA) cmpa_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpb_q     <= '0;
            cap_flag_q <= 1'b0;
        end else begin
            cap_flag_q <= ctrl_q.cap_sel & edge_ok;
            if (ctrl_q.cap_sel && edge_ok) begin
                cmpb_q <= cnt;
            end else if (wr_en && wsel == ADDR_CMPB) begin
                cmpb_q <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout_q <= 1'b0;
        end else if (ctrl_q.out_en && hit[0]) begin
            tout_q <= ~tout_q;
        end
    end

    tmr16_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (tmr_pin_i),
        .sel_i  (ctrl_q.edge_sel),
        .block_i(ctrl_q.out_en),
        .edge_o (edge_ok)
    );

    generate
        for (genvar g = 0; g < NCMP; g++) begin : g_cmp
            tmr16_match #(
                .W(W)
            ) u_match (
                .cnt_i    (cnt),
                .cmp_i    ((g == 0) ? cmpa_q : cmpb_q),
                .running_i(running),
                .wrapped_i(wrapped),
                .hit_o    (hit[g])
            );
        end
    endgenerate

    tmr16_counter #(
        .W(W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_req_i   (ctrl_q.run),
        .mode_i      (ctrl_q.mode),
        .period_hit_i(hit[0]),
        .ext_edge_i  (edge_ok),
        .cnt_o       (cnt),
        .running_o   (running),
        .wrapped_o   (wrapped)
    );

    assign cnt_o     = cnt;
    assign cmpb_o    = cmpb_q;
    assign irq_a_o   = hit[0];
    assign irq_b_o   = ctrl_q.cap_sel ? cap_flag_q : hit[1];
    assign tmr_out_o = tout_q;
    assign tmr_oe_o  = ctrl_q.out_en;

endmodule

// File: rtl/tmr16_dualcc_chk.sv
module tmr16_dualcc_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmpa,
    input logic [W-1:0] cmpb,
    input logic         irq_a,
    input logic         tout,
    input logic         oe,
    input logic         running,
    input logic [1:0]   mode,
    input logic         cap_sel,
    input logic         edge_ok
);
    localparam logic [W-1:0] ALL_ONES = '1;

    assert_stop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (cnt == '0));

    assert_free_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (mode == 2'b00 || mode == 2'b11)) |=> (cnt == $past(cnt) + W'(1)));

    assert_clear_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode == 2'b01 && cmpa != '0 && cnt == cmpa) |=> (cnt == '0));

    assert_clear_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode == 2'b10 && edge_ok) |=> (cnt == '0));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a && cmpa != '0 && !(wr_en && wr_addr == 2'b00)) |=> !irq_a);

    assert_zero_after_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a && cmpa == '0) |-> ($past(cnt) == ALL_ONES));

    assert_capture_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_sel && edge_ok) |=> (cmpb == $past(cnt)));

    assert_pin_out_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !edge_ok);

    assert_tout_on_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tout != $past(tout)) |-> $past(irq_a && oe));

endmodule

bind tmr16_dualcc tmr16_dualcc_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .cnt    (cnt_o),
    .cmpa   (cmpa_q),
    .cmpb   (cmpb_o),
    .irq_a  (irq_a_o),
    .tout   (tmr_out_o),
    .oe     (tmr_oe_o),
    .running(running),
    .mode   (ctrl_q.mode),
    .cap_sel(ctrl_q.cap_sel),
    .edge_ok(edge_ok)
);

// File: tb/tmr16_dualcc_bench.sv
module tmr16_dualcc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic        pin = 1'b0;
    logic [15:0] cnt_o, cmpb_o;
    logic        irq_a_o, irq_b_o, tmr_out_o, tmr_oe_o;

    always #4 clk = ~clk;

    tmr16_dualcc u_tmr16_dualcc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tmr_pin_i(pin),
        .cnt_o    (cnt_o),
        .cmpb_o   (cmpb_o),
        .irq_a_o  (irq_a_o),
        .irq_b_o  (irq_b_o),
        .tmr_out_o(tmr_out_o),
        .tmr_oe_o (tmr_oe_o)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned ia_seen = 0;
    int unsigned ib_seen = 0;
    string       cur_req = "R1";
    bit          done = 1'b0;

    // reference state
    logic [15:0] m_cnt = 0, m_a = 0, m_b = 0;
    logic [6:0]  m_ctrl = 0;
    logic        m_run = 0, m_wrap = 0, m_capf = 0, m_tout = 0;
    logic        m_s1 = 0, m_s2 = 0, m_s3 = 0;

    function automatic logic hit_f(logic run, logic [15:0] c, logic [15:0] r, logic wr);
        return run && (c == r) && (c != 16'h0 || wr);
    endfunction

    function automatic logic edge_f(logic [1:0] sel, logic s2, logic s3, logic oe);
        logic e;
        case (sel)
            2'b01:   e = s2 & ~s3;
            2'b10:   e = ~s2 & s3;
            2'b11:   e = s2 ^ s3;
            default: e = 1'b0;
        endcase
        return e & ~oe;
    endfunction

    task automatic model_step();
        logic        ev, ha;
        logic [15:0] nc;
        logic        nw;
        ev = edge_f(m_ctrl[5:4], m_s2, m_s3, m_ctrl[6]);
        ha = hit_f(m_run, m_cnt, m_a, m_wrap);
        if (!m_run) nc = 16'h0;
        else if (m_ctrl[1:0] == 2'b01 && ha) nc = 16'h0;
        else if (m_ctrl[1:0] == 2'b10 && ev) nc = 16'h0;
        else nc = m_cnt + 16'h1;
        nw = m_run && (m_cnt == 16'hFFFF);
        if (m_ctrl[6] && ha) m_tout = ~m_tout;
        if (m_ctrl[3] && ev) m_b = m_cnt;
        else if (wr_en && wr_addr == 2'b01) m_b = wr_data;
        m_capf = m_ctrl[3] && ev;
        if (wr_en && wr_addr == 2'b00) m_a = wr_data;
        m_run = m_ctrl[2];
        if (wr_en && wr_addr == 2'b10) m_ctrl = wr_data[6:0];
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
        m_cnt = nc; m_wrap = nw;
    endtask

    task automatic compare();
        logic ea, eb;
        ea = hit_f(m_run, m_cnt, m_a, m_wrap);
        eb = m_ctrl[3] ? m_capf : hit_f(m_run, m_cnt, m_b, m_wrap);
        n_vec++;
        if (irq_a_o === 1'b1) ia_seen++;
        if (irq_b_o === 1'b1) ib_seen++;
        if (cnt_o !== m_cnt || cmpb_o !== m_b || irq_a_o !== ea || irq_b_o !== eb
            || tmr_out_o !== m_tout || tmr_oe_o !== m_ctrl[6]) begin
            n_bad++;
            $display("FAIL %s: cnt/cmpb/ia/ib/out/oe actual %h/%h/%b/%b/%b/%b expected %h/%h/%b/%b/%b/%b",
                     cur_req, cnt_o, cmpb_o, irq_a_o, irq_b_o, tmr_out_o, tmr_oe_o,
                     m_cnt, m_b, ea, eb, m_tout, m_ctrl[6]);
        end
    endtask

    task automatic check_val(string req, int unsigned act, int unsigned exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        wr_en = 1'b0;
    endtask

    task automatic idle(int unsigned n);
        for (int unsigned i = 0; i < n; i++) cycle();
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cycle();
    endtask

    task automatic toggle_run(int unsigned n, int unsigned period);
        for (int unsigned i = 0; i < n; i++) begin
            if (period == 0) begin
                if ($urandom_range(0, 5) == 0) pin = ~pin;
            end else if (i % period == 0) begin
                pin = ~pin;
            end
            cycle();
        end
    endtask

    initial begin
        int unsigned b_before;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        wr(2'b00, 16'h1234);
        wr(2'b01, 16'h0ABC);
        wr(2'b11, 16'h5555);
        wr(2'b10, 16'h0040);
        idle(2);
        wr(2'b10, 16'h0000);

        cur_req = "R3";
        wr(2'b00, 16'hF000);
        wr(2'b01, 16'hF000);
        wr(2'b10, 16'h0004);
        idle(20);
        wr(2'b10, 16'h0000);
        idle(5);
        check_val("R3", cnt_o, 0);

        cur_req = "R5";
        wr(2'b00, 16'h0005);
        wr(2'b10, 16'h0045);
        idle(40);
        cur_req = "R12";
        wr(2'b10, 16'h0005);
        idle(20);
        wr(2'b10, 16'h0000);

        cur_req = "R6";
        wr(2'b01, 16'h0030);
        wr(2'b10, 16'h0016);
        toggle_run(120, 9);
        wr(2'b10, 16'h0000);

        cur_req = "R11";
        for (int s = 1; s < 4; s++) begin
            wr(2'b10, 16'h000C | 16'(s << 4));
            toggle_run(90, 0);
        end
        cur_req = "R10";
        wr(2'b10, 16'h003C);
        toggle_run(60, 5);

        cur_req = "R12";
        wr(2'b10, 16'h007E);
        idle(4);
        b_before = cmpb_o;
        toggle_run(50, 4);
        check_val("R12", cmpb_o, b_before);
        wr(2'b10, 16'h0000);

        cur_req = "R7";
        for (int r = 0; r < 40; r++) begin
            logic [15:0] c;
            c = 16'($urandom_range(0, 127));
            c[2] = ($urandom_range(0, 7) != 0);
            wr(2'b00, 16'($urandom_range(1, 80)));
            wr(2'b01, 16'($urandom_range(0, 80)));
            wr(2'b10, c);
            for (int k = 0; k < 150; k++) begin
                if ($urandom_range(0, 5) == 0) pin = ~pin;
                if ($urandom_range(0, 40) == 0) begin
                    wr_en = 1'b1;
                    wr_addr = 2'($urandom_range(0, 1));
                    wr_data = 16'($urandom_range(1, 80));
                end
                cycle();
            end
        end
        wr(2'b10, 16'h0000);

        cur_req = "R4";
        pin = 1'b0;
        wr(2'b01, 16'h0000);
        wr(2'b00, 16'h0300);
        idle(4);
        ia_seen = 0; ib_seen = 0;
        wr(2'b10, 16'h0004);
        idle(520);
        check_val("R8", ib_seen, 0);
        check_val("R9", ia_seen, 0);
        cur_req = "R9";
        wr(2'b00, 16'h0080);
        idle(65536 + 200);
        check_val("R8", ib_seen, 1);
        check_val("R9", ia_seen, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule